// File: doc/BRIEF.md
# Serial Zero Tally with Dual Self-Clear

This block watches a one-bit serial stream, one bit per clock, and presents on a 2-bit output the number of 0 bits seen since it last cleared. It keeps a running count of 1 bits next to the count of 0 bits. Either count reaching three clears the machine.

The output is a Moore output and depends only on the state. When the third 0 arrives, the output shows 3 for exactly one cycle. The bit that follows is then the first bit of a fresh tally. When the third 1 arrives, the machine returns straight to its cleared state and the output reads 0.

While counting, each count lies between 0 and 2. Those nine pairs, plus one display state for the value 3, make up the ten states. An active-high synchronous reset forces the cleared state.

Top module: `zero_tally`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next output `xy` is 0 and both counts are cleared.
- R2: A 0 bit taken while the zero count is 0 or 1 raises `xy` by one in the next cycle. Here `xy` is the zero count as an unsigned binary number, with bit 1 as the most significant bit.
- R3: A 0 bit taken while the zero count is 2 makes `xy` equal 3 in the next cycle, and only for that one cycle.
- R4: The bit taken while `xy` is 3 is the first bit of a new tally. A 0 gives `xy` = 1 next. A 1 gives `xy` = 0 next, with one 1 counted.
- R5: A 1 bit taken while the one count is below 2 leaves `xy` unchanged. The exception is the display cycle of R4.
- R6: A 1 bit taken while the one count is 2 gives `xy` = 0 next and clears both counts.
- R7: The one count builds up across interleaved 0 bits. With the bits 1,0,1,0,1 from a cleared state, the fifth bit clears the machine even though two 0s are counted.
- R8: Reaching the third 0 also clears the one count. With the bits 1,1,0,0,0 from a cleared state, the next two 1 bits do not clear anything, and a 0 that follows them gives `xy` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Serial data bit, one per clock |
| xy | output | 2 | Count of 0 bits since the last clear (3 for one cycle after the third 0) |

## Verification
The hardest states to reach are those where both counts are high at once. One is the third 1 arriving after two 0s. Another is a one count left over when the third 0 lands, which must be cleared rather than carried on. Directed sequences interleave 0s and 1s to reach each of these, and a following bit shows whether the hidden one count was kept or cleared. A long run of pseudo-random bits from a fixed LFSR then passes repeatedly through every pair of counts and through the display state.

// File: rtl/zero_tally.sv
module zero_tally (
  input  logic       clk,
  input  logic       rst,
  input  logic       a_in,
  output logic [1:0] xy
);

  localparam logic [1:0] TOP   = 2'd2;
  localparam logic [1:0] SHOW3 = 2'd3;

  logic [1:0] zc, oc;
  logic [1:0] zc_nx, oc_nx;
  logic [1:0] zbase;

  assign zbase = (zc == SHOW3) ? 2'd0 : zc;

  always_comb begin
    zc_nx = zbase;
    oc_nx = oc;
    if (!a_in) begin
      if (zbase == TOP) begin
        zc_nx = SHOW3;
        oc_nx = 2'd0;
      end else begin
        zc_nx = zbase + 2'd1;
      end
    end else if (oc == TOP) begin
      zc_nx = 2'd0;
      oc_nx = 2'd0;
    end else begin
      oc_nx = oc + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zc <= 2'd0;
      oc <= 2'd0;
    end else begin
      zc <= zc_nx;
      oc <= oc_nx;
    end
  end

  assign xy = zc;

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (xy == 2'd0 && oc == 2'd0)); // R1
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!a_in && xy < 2'd2) |=> (xy == $past(xy) + 2'd1)); // R2
  AST_THIRD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!a_in && xy == 2'd2) |=> (xy == 2'd3 && oc == 2'd0)); // R3
  AST_SHOW_ONCE: assert property (@(posedge clk) disable iff (rst)
    (xy == 2'd3) |=> (xy != 2'd3)); // R3
  AST_AFTER_SHOW: assert property (@(posedge clk) disable iff (rst)
    (xy == 2'd3 && a_in) |=> (xy == 2'd0 && oc == 2'd1)); // R4
  AST_ONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a_in && oc != 2'd2 && xy != 2'd3) |=> $stable(xy)); // R5
  AST_THIRD_ONE: assert property (@(posedge clk) disable iff (rst)
    (a_in && oc == 2'd2) |=> (xy == 2'd0 && oc == 2'd0)); // R6

endmodule

// File: tb/zero_tally_bench.sv
module zero_tally_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_in = 1'b0;
  logic [1:0] xy;

  int checks = 0;
  int fails = 0;
  int mz = 0;
  int mo = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  zero_tally u_zero_tally (.clk(clk), .rst(rst), .a_in(a_in), .xy(xy));

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    mz = 0;
    mo = 0;
    exp_q.push_back(0);
    tag_q.push_back(tag);
  endtask

  task automatic send(bit b, string tag);
    @(negedge clk);
    rst = 1'b0;
    a_in = b;
    if (mz == 3) mz = 0;
    if (!b) begin
      if (mz == 2) begin mz = 3; mo = 0; end
      else mz = mz + 1;
    end else begin
      if (mo == 2) begin mz = 0; mo = 0; end
      else mo = mo + 1;
    end
    exp_q.push_back(mz);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() != 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(xy) != e) begin
        fails++;
        $display("FAIL %s: xy=%0d expected %0d at %0t", t, xy, e, $time);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (2) @(negedge clk);
    do_reset("R1 reset state");
    // R2 and R3: count up to the display state
    send(0, "R2"); send(0, "R2"); send(0, "R3");
    // R4: a 0 after the display starts a new tally
    send(0, "R4"); send(1, "R5"); send(0, "R2");
    send(1, "R5"); send(1, "R6");
    // R4: a 1 after the display
    send(0, "R2"); send(0, "R2"); send(0, "R3");
    send(1, "R4"); send(1, "R4"); send(1, "R6");
    // R7: ones build up across zeros
    do_reset("R1");
    send(1, "R7"); send(0, "R7"); send(1, "R7"); send(0, "R7"); send(1, "R7");
    send(0, "R7");
    // R8: ones cleared by the third zero
    do_reset("R1");
    send(1, "R8"); send(1, "R8"); send(0, "R8"); send(0, "R8"); send(0, "R8");
    send(1, "R8"); send(1, "R8"); send(0, "R8");
    // R1: reset mid-count clears both counts
    send(1, "R1"); send(1, "R1"); send(0, "R1");
    do_reset("R1");
    send(1, "R1 ones cleared"); send(1, "R1 ones cleared"); send(0, "R1 ones cleared");
    // pseudo-random run
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send(lfsr[0], "R5 random");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule